// File: doc/BRIEF.md
# Flow-Controlled Asynchronous Serial Receiver

This block receives asynchronous serial characters on a line that rests high. A falling edge opens a frame. The receiver re-checks the line at the middle of the start bit and then samples every later bit at its centre, counting a 16x oversampling strobe. The data bits arrive least significant bit first. An optional parity bit follows them, and then one or two stop bits. Each completed character is stored in a four-entry buffer together with a parity-error flag and a framing-error flag. The host sees the oldest entry on a show-ahead read port and removes it with a one-cycle read strobe.

The receiver drives an active-low request-to-send output that tells the remote transmitter whether it may send. That output goes high once three characters are buffered, which leaves room for one character that may already be on the wire. If a character completes while the buffer is full, the character is dropped and a sticky overrun flag is raised. The flag stays set until the host clears it.

The frame shape is set by four static inputs: 7 or 8 data bits, parity enable, odd or even parity, and one or two stop bits. Together they give frames of 9 to 12 bit times. The frame state machine uses seven states:
- `S_IDLE` waits for a low line and goes to `S_START`.
- `S_START` counts to mid-bit. It returns to `S_IDLE` if the line is high there, and goes to `S_DATA` if the line is low.
- `S_DATA` samples the data bits. It goes to `S_PARITY` when parity is enabled, and to `S_STOP1` otherwise.
- `S_PARITY` samples the parity bit and goes to `S_STOP1`.
- `S_STOP1` goes to `S_STOP2` when two stop bits are selected. Otherwise it goes to `S_IDLE`, or to `S_BREAK` if the stop sample is low.
- `S_STOP2` goes to `S_IDLE`, or to `S_BREAK` on a low sample.
- `S_BREAK` waits for the line to return high and then goes to `S_IDLE`.

Top module: `uart_rx_fc`

## Requirements
- R1: After reset, `rd_valid` is 0, `rts_n` is 0 and `ovr_flag` is 0.
- R2: A low pulse on `rxd` that is back high by the middle of the start bit is rejected, and no character is stored.
- R3: Data bits are assembled least significant bit first. With `cfg_len8`=1, 8 bits are received. With `cfg_len8`=0, 7 bits are received, and `rd_data[7]` reads 0.
- R4: With `cfg_par_en`=1, the expected parity bit is the XOR of the data bits (`cfg_par_odd`=0) or the inverse of that XOR (`cfg_par_odd`=1). A mismatch sets `rd_perr` for that character. With `cfg_par_en`=0, no parity bit is expected and `rd_perr` is 0 whatever `cfg_par_odd` is.
- R5: A low sample in any stop bit (one with `cfg_stop2`=0, two with `cfg_stop2`=1) sets `rd_ferr` for that character. After a low final stop bit, the receiver waits for the line to go high before it looks for a new start.
- R6: The buffer holds up to 4 characters and returns them oldest first. `rd_valid` is 1 exactly when the buffer is not empty.
- R7: `rts_n` is 1 while the buffer holds 3 or more characters, and 0 while it holds 2 or fewer.
- R8: A character that completes while the buffer is full and not being read is discarded, and `ovr_flag` is set. The flag stays 1 until `ovr_clr` is pulsed, and the buffered characters are not changed.
- R9: `rd_en` while the buffer is empty has no effect: `rd_valid` stays 0 and `rts_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| rd_en | input | 1 | Pops the oldest character |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Oldest buffered character |
| rd_perr | output | 1 | Parity error of the oldest character |
| rd_ferr | output | 1 | Framing error of the oldest character |
| rd_valid | output | 1 | Buffer not empty |
| rts_n | output | 1 | Active-low permission for the far end to send |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The hardest situation to reach is overrun. A well-behaved far end stops sending when `rts_n` rises, so a fifth character never arrives. The bench plays a transmitter that ignores `rts_n` and sends five back-to-back frames without reading. It then drains the buffer, confirms that only the first four characters come out in order, and checks that the flag survives until it is cleared. A second hard case is a low stop bit that runs straight into a possible new start. The bench holds the full stop bit low and then checks that the next frame is still received correctly.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP1,
        S_STOP2,
        S_BREAK
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_entry_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    input  logic      cfg_len8,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    input  logic      cfg_stop2,
    output logic      done_o,
    output rx_entry_t entry_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_FULL  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(DATA_W - 2);

    rx_state_t         st, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic              par_bit;
    logic              ferr_acc;
    logic [IDX_W-1:0]  last_idx;
    logic              at_mid;
    logic              at_end;

    assign last_idx = cfg_len8 ? IDX_FULL : IDX_SHORT;
    assign at_mid   = tick && (cnt == MID_C);
    assign at_end   = tick && (cnt == LAST_C);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:   if (!rx) nxt = S_START;
            S_START:  if (at_mid) nxt = rx ? S_IDLE : S_DATA;
            S_DATA:   if (at_end && bit_idx == last_idx)
                          nxt = cfg_par_en ? S_PARITY : S_STOP1;
            S_PARITY: if (at_end) nxt = S_STOP1;
            S_STOP1:  if (at_end) begin
                          if (cfg_stop2) nxt = S_STOP2;
                          else           nxt = rx ? S_IDLE : S_BREAK;
                      end
            S_STOP2:  if (at_end) nxt = rx ? S_IDLE : S_BREAK;
            S_BREAK:  if (rx) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            par_bit  <= 1'b0;
            ferr_acc <= 1'b0;
            done_o   <= 1'b0;
            entry_o  <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    cnt      <= '0;
                    bit_idx  <= '0;
                    par_acc  <= 1'b0;
                    ferr_acc <= 1'b0;
                end
                S_START: if (tick) cnt <= (cnt == MID_C) ? '0 : cnt + 1'b1;
                S_DATA: if (tick) begin
                    if (cnt == LAST_C) begin
                        shreg   <= {rx, shreg[DATA_W-1:1]};
                        par_acc <= par_acc ^ rx;
                        bit_idx <= bit_idx + 1'b1;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_PARITY: if (tick) begin
                    if (cnt == LAST_C) begin
                        par_bit <= rx;
                        cnt     <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_STOP1: if (tick) begin
                    if (cnt == LAST_C) begin
                        cnt      <= '0;
                        ferr_acc <= !rx;
                        if (!cfg_stop2) begin
                            done_o       <= 1'b1;
                            entry_o.data <= cfg_len8 ? shreg : (shreg >> 1);
                            entry_o.perr <= cfg_par_en && (par_bit != (par_acc ^ cfg_par_odd));
                            entry_o.ferr <= !rx;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_STOP2: if (tick) begin
                    if (cnt == LAST_C) begin
                        cnt          <= '0;
                        done_o       <= 1'b1;
                        entry_o.data <= cfg_len8 ? shreg : (shreg >> 1);
                        entry_o.perr <= cfg_par_en && (par_bit != (par_acc ^ cfg_par_odd));
                        entry_o.ferr <= ferr_acc || !rx;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_BREAK: cnt <= '0;
                default: cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_entry_t                  wdata,
    input  logic                       pop,
    output rx_entry_t                  rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    rx_entry_t       mem [DEPTH];
    logic [PW-1:0]   wptr, rptr;

    assign full  = (count == FULL_C);
    assign empty = (count == '0);
    assign rdata = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end
endmodule

// File: rtl/uart_rx_fc.sv
module uart_rx_fc
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int RTS_LEVEL   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              cfg_len8,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic              rd_en,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_perr,
    output logic              rd_ferr,
    output logic              rd_valid,
    output logic              rts_n,
    output logic              ovr_flag
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [CW-1:0] RTS_C = CW'(RTS_LEVEL);

    logic          rx_s;
    logic          fr_done;
    rx_entry_t     fr_entry;
    rx_entry_t     head;
    logic [CW-1:0] occ;
    logic          f_full, f_empty;
    logic          pop_ok, push_ok, drop;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rx_s)
    );

    uart_rx_fsm #(.OVS(OVS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .rx          (rx_s),
        .cfg_len8    (cfg_len8),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop2   (cfg_stop2),
        .done_o      (fr_done),
        .entry_o     (fr_entry)
    );

    assign pop_ok  = rd_en && !f_empty;
    assign push_ok = fr_done && (!f_full || pop_ok);
    assign drop    = fr_done && f_full && !pop_ok;

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .wdata (fr_entry),
        .pop   (pop_ok),
        .rdata (head),
        .count (occ),
        .full  (f_full),
        .empty (f_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_flag <= 1'b0;
        else if (drop)    ovr_flag <= 1'b1;
        else if (ovr_clr) ovr_flag <= 1'b0;
    end

    assign rts_n    = (occ >= RTS_C);
    assign rd_valid = !f_empty;
    assign rd_data  = head.data;
    assign rd_perr  = head.perr;
    assign rd_ferr  = head.ferr;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
    parameter int DEPTH     = 4,
    parameter int RTS_LEVEL = 3
) (
    input logic clk,
    input logic rst_n,
    input logic rd_en,
    input logic ovr_clr,
    input logic cfg_par_en,
    input logic fr_done,
    input logic fr_perr,
    input logic rd_valid,
    input logic rts_n,
    input logic ovr_flag
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] RTS_C  = CW'(RTS_LEVEL);

    logic [CW-1:0] cnt_m;
    logic          pop_m, push_m;

    assign pop_m  = rd_en && (cnt_m != '0);
    assign push_m = fr_done && ((cnt_m != FULL_C) || pop_m);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_m <= '0;
        else        cnt_m <= cnt_m + CW'(push_m) - CW'(pop_m);
    end

    a_r7_rts_level: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n == (cnt_m >= RTS_C));

    a_r6_valid_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (cnt_m != '0));

    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && cnt_m == FULL_C && !rd_en) |=> ovr_flag);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && rd_en && !fr_done) |=> (!rd_valid && !rts_n));

    a_r4_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_par_en && $rose(fr_done)) |-> !fr_perr);
endmodule

bind uart_rx_fc uart_rx_chk #(.DEPTH(FIFO_DEPTH), .RTS_LEVEL(RTS_LEVEL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .ovr_clr    (ovr_clr),
    .cfg_par_en (cfg_par_en),
    .fr_done    (fr_done),
    .fr_perr    (fr_entry.perr),
    .rd_valid   (rd_valid),
    .rts_n      (rts_n),
    .ovr_flag   (ovr_flag)
);

// File: tb/sim_uart_rx_fc.sv
`timescale 1ns/1ps
module sim_uart_rx_fc;
    localparam int BIT_CYC = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic       rxd = 1'b1;
    logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic       rd_en = 1'b0, ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_valid, rts_n, ovr_flag;
    int         n_cmp = 0, n_mis = 0;

    always #5 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;
    end

    uart_rx_fc u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .rd_en(rd_en), .ovr_clr(ovr_clr),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .rd_valid(rd_valid), .rts_n(rts_n), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int cyc);
        rxd = v;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic bad_par,
                        input logic bad_s1, input logic bad_s2);
        int   n = cfg_len8 ? 8 : 7;
        logic p = 1'b0;
        hold(1'b0, BIT_CYC);
        for (int i = 0; i < n; i++) begin
            p ^= d[i];
            hold(d[i], BIT_CYC);
        end
        if (cfg_par_en) hold(p ^ cfg_par_odd ^ bad_par, BIT_CYC);
        hold(!bad_s1, BIT_CYC);
        if (cfg_stop2) hold(!bad_s2, BIT_CYC);
        hold(1'b1, 8);
    endtask

    task automatic pop_expect(input string tag, input logic [7:0] d,
                              input logic pe, input logic fe);
        chk({tag, " valid"}, rd_valid, 1);
        chk({tag, " data"},  rd_data, d);
        chk({tag, " perr"},  rd_perr, pe);
        chk({tag, " ferr"},  rd_ferr, fe);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic l8, input logic pe, input logic po, input logic s2);
        cfg_len8 = l8; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    endtask

    task automatic t_reset();
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 rts_n", rts_n, 0);
        chk("R1 ovr_flag", ovr_flag, 0);
    endtask

    task automatic t_glitch();
        set_cfg(1, 0, 0, 0);
        hold(1'b0, 10);
        hold(1'b1, 3 * BIT_CYC);
        chk("R2 glitch rejected", rd_valid, 0);
        send(8'h3E, 0, 0, 0);
        pop_expect("R2 after glitch", 8'h3E, 0, 0);
    endtask

    task automatic t_data();
        set_cfg(1, 0, 0, 0);
        send(8'hA5, 0, 0, 0);
        pop_expect("R3 8bit A5", 8'hA5, 0, 0);
        send(8'h01, 0, 0, 0);
        pop_expect("R3 8bit 01", 8'h01, 0, 0);
        set_cfg(0, 0, 0, 0);
        send(8'h55, 0, 0, 0);
        pop_expect("R3 7bit 55", 8'h55, 0, 0);
        send(8'h7F, 0, 0, 0);
        pop_expect("R3 7bit 7F", 8'h7F, 0, 0);
    endtask

    task automatic t_parity();
        set_cfg(1, 1, 0, 0);
        send(8'h3C, 0, 0, 0);
        pop_expect("R4 even ok", 8'h3C, 0, 0);
        send(8'h3C, 1, 0, 0);
        pop_expect("R4 even bad", 8'h3C, 1, 0);
        set_cfg(1, 1, 1, 0);
        send(8'h01, 0, 0, 0);
        pop_expect("R4 odd ok", 8'h01, 0, 0);
        send(8'h01, 1, 0, 0);
        pop_expect("R4 odd bad", 8'h01, 1, 0);
        set_cfg(0, 1, 1, 1);
        send(8'h46, 1, 0, 0);
        pop_expect("R4 7bit odd 2stop bad", 8'h46, 1, 0);
        set_cfg(1, 0, 1, 0);
        send(8'h07, 0, 0, 0);
        pop_expect("R4 disabled", 8'h07, 0, 0);
    endtask

    task automatic t_framing();
        set_cfg(1, 0, 0, 0);
        send(8'h81, 0, 1, 0);
        pop_expect("R5 stop low", 8'h81, 0, 1);
        send(8'hC3, 0, 0, 0);
        pop_expect("R5 after break", 8'hC3, 0, 0);
        set_cfg(1, 1, 0, 1);
        send(8'h18, 0, 0, 1);
        pop_expect("R5 second stop low", 8'h18, 0, 1);
        send(8'h18, 0, 1, 0);
        pop_expect("R5 first stop low", 8'h18, 0, 1);
        send(8'h99, 0, 0, 0);
        pop_expect("R5 two stops ok", 8'h99, 0, 0);
    endtask

    task automatic t_fifo_rts();
        set_cfg(1, 0, 0, 0);
        send(8'h11, 0, 0, 0);
        send(8'h22, 0, 0, 0);
        chk("R7 two held rts_n", rts_n, 0);
        send(8'h33, 0, 0, 0);
        chk("R7 three held rts_n", rts_n, 1);
        send(8'h44, 0, 0, 0);
        chk("R7 four held rts_n", rts_n, 1);
        pop_expect("R6 order 1", 8'h11, 0, 0);
        chk("R7 back to three rts_n", rts_n, 1);
        pop_expect("R6 order 2", 8'h22, 0, 0);
        chk("R7 back to two rts_n", rts_n, 0);
        pop_expect("R6 order 3", 8'h33, 0, 0);
        pop_expect("R6 order 4", 8'h44, 0, 0);
        chk("R6 drained", rd_valid, 0);
    endtask

    task automatic t_overrun();
        set_cfg(1, 0, 0, 0);
        send(8'hA1, 0, 0, 0);
        send(8'hA2, 0, 0, 0);
        send(8'hA3, 0, 0, 0);
        send(8'hA4, 0, 0, 0);
        chk("R8 no overrun at four", ovr_flag, 0);
        send(8'hA5, 0, 0, 0);
        chk("R8 overrun set", ovr_flag, 1);
        pop_expect("R8 keep 1", 8'hA1, 0, 0);
        pop_expect("R8 keep 2", 8'hA2, 0, 0);
        pop_expect("R8 keep 3", 8'hA3, 0, 0);
        pop_expect("R8 keep 4", 8'hA4, 0, 0);
        chk("R8 fifth dropped", rd_valid, 0);
        chk("R8 sticky", ovr_flag, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R8 cleared", ovr_flag, 0);
    endtask

    task automatic t_empty_pop();
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk("R9 empty valid", rd_valid, 0);
        chk("R9 empty rts_n", rts_n, 0);
        set_cfg(1, 0, 0, 0);
        send(8'h5C, 0, 0, 0);
        pop_expect("R9 next char", 8'h5C, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_glitch();
        t_data();
        t_parity();
        t_framing();
        t_fifo_rts();
        t_overrun();
        t_empty_pop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_mis++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule